// File: doc/BRIEF.md
# Edge-Latched Chained Interrupt Aggregator

This block collects interrupt events from a parameterized set of sources and reports them to a parent interrupt controller on one output. Each source goes through a synchronizer and a rising-edge detector. A detected edge sets a bit in a pending-event register, and that bit stays set until software acknowledges it. A second register holds one enable bit per source. The output asserts while any pending bit is also enabled.

Software reaches the two registers through a simple word-wide port: a write strobe, a byte address, write data and a read-data bus that always reflects the addressed register. Pending bits latch edges even while their enable bit is clear. To drop a stale event, software writes zero to that pending bit, and it should do so before it enables the source. Writing one to a pending bit leaves that bit unchanged.

The output is produced by a two-state machine. The machine stays in state QUIET while no enabled event is pending, and it moves to state RAISED on the cycle after one is pending. It returns from RAISED to QUIET on the cycle after the last enabled pending bit is cleared or disabled. There are only two transitions: QUIET to RAISED, and RAISED to QUIET.

Top module: `edge_irq_aggregator`

## Requirements
- R1: After reset, the pending register (offset 0x0) and the enable register (offset 0x4) read as zero, and `irq_out` is low.
- R2: A rising edge on `src_in[i]` sets pending bit i. The bit is readable on the third clock edge after the input rises (two synchronizer stages plus the edge register). A falling edge or a steady level sets nothing.
- R3: Pending bits latch edges whatever the enable bits are. With no edge and no write to offset 0x0, the pending register holds its value, including across writes to the enable register.
- R4: A write to offset 0x0 clears every pending bit whose write-data bit is 0 and leaves every bit whose write-data bit is 1 unchanged. Writing all zeros clears every pending event.
- R5: When an edge on a source is detected in the same cycle that a write clears that source's pending bit, the edge wins and the bit stays set.
- R6: A write to offset 0x4 loads the enable register, bit i enabling source i, and a read of offset 0x4 returns it on the next cycle. Writing zero disables all sources.
- R7: `irq_out` is high exactly one clock after a cycle in which some bit is set in both the pending and the enable register, and low one clock after a cycle in which none is.
- R8: Read-data bits at positions N_SRC and above always read as zero, and write data in those positions is ignored.
- R9: A write to any address other than 0x0 and 0x4 changes neither register. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Asynchronous event inputs, rising-edge sensitive |
| bus_wr | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Byte address of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| irq_out | output | 1 | Chained interrupt request to the parent controller |

## Verification
Each result is due at a fixed number of clock edges after its stimulus:
- A rising input becomes readable as a pending bit after three edges.
- A register write is readable after one edge.
- `irq_out` follows one edge after the pending/enable state it depends on.

The bench drives inputs at falling edges and counts exactly these edges before it samples at a falling edge. The same-cycle race is provoked by placing the acknowledge write on the third edge after the input rises. The sweeps run over every enable value and every acknowledge pattern of an eight-source configuration, and each expected value is computed as a bitwise product of the stimulus words.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    // Byte offsets of the two software-visible registers.
    localparam int PEND_OFS = 0;
    localparam int ENA_OFS  = 4;

    // Output state machine encoding.
    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } out_state_e;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= level;
        end
    end

    // One pulse per low-to-high transition of each synchronized input.
    assign rise = level & ~prev_q;

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  rise,
    input  logic              pend_wr,
    input  logic              ena_wr,
    input  logic [N_SRC-1:0]  wdata_lo,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N_SRC-1:0]  pend_q,
    output logic [N_SRC-1:0]  ena_q,
    output logic [DATA_W-1:0] rdata
);

    logic [N_SRC-1:0] pend_kept;

    // A write keeps only bits written as one; new edges are merged last so they win.
    always_comb begin
        pend_kept = pend_wr ? (pend_q & wdata_lo) : pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_kept | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (ena_wr) begin
            ena_q <= wdata_lo;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rd_addr)
            ADDR_W'(PEND_OFS): rdata[N_SRC-1:0] = pend_q;
            ADDR_W'(ENA_OFS):  rdata[N_SRC-1:0] = ena_q;
            default:           rdata = '0;
        endcase
    end

endmodule

// File: rtl/edge_irq_outfsm.sv
module edge_irq_outfsm
    import edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    output logic irq
);

    out_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any_pend)  state_d = ST_RAISED;
            ST_RAISED: if (!any_pend) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            ST_QUIET:  irq = 1'b0;
            ST_RAISED: irq = 1'b1;
            default:   irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/edge_irq_aggregator.sv
module edge_irq_aggregator
    import edge_irq_pkg::*;
#(
    parameter int N_SRC       = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [N_SRC-1:0] sync_w;
    logic [N_SRC-1:0] rise_w;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] ena_q;
    logic [N_SRC-1:0] wdata_lo;
    logic             pend_wr;
    logic             ena_wr;
    logic             any_pend;

    assign wdata_lo = bus_wdata[N_SRC-1:0];
    assign pend_wr  = bus_wr && (bus_addr == ADDR_W'(PEND_OFS));
    assign ena_wr   = bus_wr && (bus_addr == ADDR_W'(ENA_OFS));

    edge_irq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_in),
        .q     (sync_w)
    );

    edge_irq_detect #(.W(N_SRC)) detect_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_w),
        .rise  (rise_w)
    );

    edge_irq_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_w),
        .pend_wr  (pend_wr),
        .ena_wr   (ena_wr),
        .wdata_lo (wdata_lo),
        .rd_addr  (bus_addr),
        .pend_q   (pend_q),
        .ena_q    (ena_q),
        .rdata    (bus_rdata)
    );

    assign any_pend = |(pend_q & ena_q);

    edge_irq_outfsm outfsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (any_pend),
        .irq      (irq_out)
    );

endmodule

// File: rtl/edge_irq_checker.sv
module edge_irq_checker #(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  rise,
    input logic [N_SRC-1:0]  pend,
    input logic [N_SRC-1:0]  ena,
    input logic              pend_wr,
    input logic [N_SRC-1:0]  wdata_lo,
    input logic [DATA_W-1:0] rdata,
    input logic              irq
);

    // R2: a detected edge is latched on the next clock.
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));

    // R3: without edge or pending write the register holds.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_wr && (rise == '0)) |=> (pend == $past(pend)));

    // R4: bits written as zero with no competing edge clear.
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && ((pend & ~wdata_lo & ~rise) != '0))
        |=> ((pend & $past(pend & ~wdata_lo & ~rise)) == '0));

    // R5: an edge that coincides with a clear survives.
    p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && (|rise)) |=> ((pend & $past(rise)) == $past(rise)));

    // R7: output follows enabled pending state one cycle later.
    p_irq_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ena)) |=> irq);

    p_irq_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & ena)) |=> !irq);

    // R8: nothing above the configured source count is ever read.
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata >> N_SRC) == '0));

endmodule

bind edge_irq_aggregator edge_irq_checker #(.N_SRC(N_SRC), .DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise_w),
    .pend     (pend_q),
    .ena      (ena_q),
    .pend_wr  (pend_wr),
    .wdata_lo (wdata_lo),
    .rdata    (bus_rdata),
    .irq      (irq_out)
);

// File: tb/edge_irq_aggregator_tb_top.sv
module edge_irq_aggregator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 8;
    localparam int DW         = 32;
    localparam int AW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_aggregator #(.N_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Raise the given inputs, wait for latching, then drop them and let edges settle.
    task automatic pulse(input logic [NS-1:0] bits);
        src_in = bits;
        step(3);
        src_in = '0;
        step(3);
    endtask

    logic [DW-1:0] r;

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        rd(4'h0, r); check("R1 pending reset", r, 0);
        rd(4'h4, r); check("R1 enable reset", r, 0);
        check("R1 irq reset", {31'b0, irq_out}, 0);

        // R2/R3: each source alone, enables all clear
        for (int i = 0; i < NS; i++) begin
            wr(4'h0, 0);
            src_in = NS'(1) << i;
            step(2);
            rd(4'h0, r); check("R2 not before third edge", r, 0);
            step(1);
            rd(4'h0, r); check("R2 edge latched", r, DW'(1) << i);
            check("R3 masked source keeps irq low", {31'b0, irq_out}, 0);
            src_in = '0;
            step(4);
            rd(4'h0, r); check("R2 falling edge sets nothing", r, DW'(1) << i);
        end

        // R4/R8: every acknowledge pattern against an all-set register
        for (int p = 0; p < 256; p++) begin
            pulse('1);
            wr(4'h0, 32'hFFFF_FF00 | DW'(p));
            rd(4'h0, r); check("R4 acknowledge pattern", r, DW'(p));
            check("R8 upper bits zero", r >> NS, 0);
        end
        wr(4'h0, 0);
        rd(4'h0, r); check("R4 clear all", r, 0);

        // R6/R7: every enable value against a fixed pending pattern
        pulse(8'hA5);
        for (int m = 0; m < 256; m++) begin
            wr(4'h4, DW'(m));
            rd(4'h4, r); check("R6 enable readback", r, DW'(m));
            step(1);
            check("R7 irq vs enable", {31'b0, irq_out}, {31'b0, ((m & 8'hA5) != 0)});
            rd(4'h0, r); check("R3 enable write keeps pending", r, 32'hA5);
        end

        // R7: acknowledge drops output one edge after the register clears
        wr(4'h4, 32'h01);
        step(1);
        check("R7 irq high", {31'b0, irq_out}, 1);
        wr(4'h0, 32'hFE);
        check("R7 irq still high before follow edge", {31'b0, irq_out}, 1);
        step(1);
        check("R7 irq low after ack", {31'b0, irq_out}, 0);

        // R6: writing zero disables all; R8 upper enable bits ignored
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, r); check("R8 enable upper ignored", r, 32'hFF);
        wr(4'h4, 0);
        rd(4'h4, r); check("R6 disable all", r, 0);

        // R5: edge detected in the same cycle as its clear
        wr(4'h0, 0);
        pulse(8'h02);
        src_in = 8'h08;
        step(2);
        bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 0;
        step(1);
        bus_wr = 1'b0;
        src_in = '0;
        rd(4'h0, r); check("R5 edge wins over clear", r, 32'h08);
        step(3);

        // R9: unmapped addresses
        wr(4'h4, 32'h3C);
        wr(4'h8, 32'hFF);
        wr(4'hC, 32'h00);
        wr(4'h2, 32'h00);
        rd(4'h0, r); check("R9 pending untouched", r, 32'h08);
        rd(4'h4, r); check("R9 enable untouched", r, 32'h3C);
        rd(4'h8, r); check("R9 unmapped reads zero", r, 0);
        rd(4'hC, r); check("R9 unmapped reads zero", r, 0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule